// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This unit multiplies two operands of `OPW` bits (32 by default) and combines the double-width product with an accumulator of `2*OPW` bits (64 by default). It either adds the product to the accumulator or subtracts it. The operands and the accumulator are treated as two's complement or as unsigned, as the mode input selects. When the exact result does not fit the accumulator range, the result is clamped to the nearest bound and an overflow flag is raised.

The result and four status flags are captured in one output register when `valid_in` is high. Two of the flags are sticky and hold a record across operations until `clr_sticky` clears them. The advance-overflow flag warns that the result has come close to the top of its range, because its two most significant bits differ. Overflow is found from the signs or the magnitudes of the operands and of the wrapped sum. The adder is therefore only as wide as the accumulator.

Top module: `sat_mac64`

## Requirements
- R1: After a synchronous active-high reset, `result` and all four flags read zero.
- R2: In signed mode (`signed_sel`=1), both operands are sign-extended before the multiply. Without overflow, `result` equals `acc_in` plus or minus the product, modulo 2^(2*OPW).
- R3: Signed add (`sub_sel`=0) overflows when the product and `acc_in` have the same sign and the wrapped sum has the other sign. The result is then the most positive value for a non-negative product and the most negative value otherwise.
- R4: Signed subtract (`sub_sel`=1) overflows when `acc_in` and the product differ in sign and the wrapped difference differs in sign from `acc_in`. The result is then the most positive value for a negative product and the most negative value otherwise.
- R5: Unsigned add overflows when the wrapped sum is smaller than `acc_in`. The result is then all ones.
- R6: Unsigned subtract overflows when the wrapped difference is larger than `acc_in`. The result is then zero.
- R7: On a saturated operation, `ovf` and `ovf_sticky` are set. On any other operation, `ovf` is cleared and `ovf_sticky` keeps its value.
- R8: `aov` equals the XOR of the top two bits of the final, possibly clamped, result. `aov_sticky` collects `aov` by OR.
- R9: While `valid_in` is low, `result`, `ovf` and `aov` hold their values.
- R10: `clr_sticky` clears both sticky flags at the next edge. An operation accepted in the same cycle still records its own flags into them.
- R11: In unsigned mode, the operands are zero-extended. The product of two all-ones operands is therefore 2^(2*OPW) - 2^(OPW+1) + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr_sticky | input | 1 | Clears the sticky flags |
| valid_in | input | 1 | Accepts an operation this cycle |
| signed_sel | input | 1 | 1 = two's complement, 0 = unsigned |
| sub_sel | input | 1 | 1 = accumulator minus product, 0 = plus |
| op_a | input | OPW | First multiplicand |
| op_b | input | OPW | Second multiplicand |
| acc_in | input | 2*OPW | Accumulator operand |
| result | output | 2*OPW | Registered, saturated result |
| ovf | output | 1 | Last operation saturated |
| ovf_sticky | output | 1 | Some operation saturated since the last clear |
| aov | output | 1 | Top two result bits differ |
| aov_sticky | output | 1 | Advance overflow seen since the last clear |

## Verification
The bench builds a second copy of the unit with `OPW`=3, so the accumulator is 6 bits wide. With that copy it runs every combination of both operands, every accumulator value, and all four sign and direction modes. That is 16384 operations, and at this size each clamp bound and each sign pattern of the overflow rules comes up many times. The instance with the default widths is driven with directed cases that reach the full 64-bit bounds, including the zero-extended all-ones product. The expected results come from exact integer arithmetic on wide values, which is then clamped to the range.

// File: rtl/mac_pkg.sv
package mac_pkg;

    // Operation kind, decoded from the two mode inputs
    typedef enum logic [1:0] {
        MAC_U_ADD = 2'b00,
        MAC_U_SUB = 2'b01,
        MAC_S_ADD = 2'b10,
        MAC_S_SUB = 2'b11
    } mac_kind_e;

    // Flags produced by one operation
    typedef struct packed {
        logic sat;
        logic adv;
    } mac_flags_t;

    function automatic mac_kind_e mac_kind_f(input logic is_signed, input logic is_sub);
        return mac_kind_e'({is_signed, is_sub});
    endfunction

    function automatic logic kind_signed_f(input mac_kind_e k);
        return (k == MAC_S_ADD) || (k == MAC_S_SUB);
    endfunction

endpackage

// File: rtl/mac_mult.sv
module mac_mult
    import mac_pkg::*;
#(
    parameter int OPW = 32
) (
    input  mac_kind_e        kind,
    input  logic [OPW-1:0]   a,
    input  logic [OPW-1:0]   b,
    output logic [2*OPW-1:0] prod
);
    localparam int ACW = 2 * OPW;

    logic            ext_sign;
    logic [ACW-1:0]  a_ext;
    logic [ACW-1:0]  b_ext;

    assign ext_sign = kind_signed_f(kind);

    // Extend each operand to the full width; the low ACW bits of the
    // product are then correct for both interpretations.
    assign a_ext = {{OPW{ext_sign & a[OPW-1]}}, a};
    assign b_ext = {{OPW{ext_sign & b[OPW-1]}}, b};
    assign prod  = a_ext * b_ext;

endmodule

// File: rtl/mac_accum.sv
module mac_accum
    import mac_pkg::*;
#(
    parameter int ACW = 64
) (
    input  mac_kind_e      kind,
    input  logic [ACW-1:0] acc,
    input  logic [ACW-1:0] prod,
    output logic [ACW-1:0] res,
    output mac_flags_t     flags
);
    localparam int MSB = ACW - 1;
    localparam logic [ACW-1:0] S_MAX = {1'b0, {(ACW-1){1'b1}}};
    localparam logic [ACW-1:0] S_MIN = {1'b1, {(ACW-1){1'b0}}};
    localparam logic [ACW-1:0] U_MAX = {ACW{1'b1}};
    localparam logic [ACW-1:0] U_MIN = '0;

    logic [ACW-1:0] sum_w;
    logic [ACW-1:0] dif_w;
    logic           p_neg;
    logic           c_neg;
    logic           sat;

    assign sum_w = acc + prod;
    assign dif_w = acc - prod;
    assign p_neg = prod[MSB];
    assign c_neg = acc[MSB];

    always_comb begin
        sat = 1'b0;
        res = sum_w;
        unique case (kind)
            MAC_S_ADD: begin
                sat = (p_neg == c_neg) && (sum_w[MSB] != p_neg);
                res = sat ? (p_neg ? S_MIN : S_MAX) : sum_w;
            end
            MAC_S_SUB: begin
                sat = (p_neg != c_neg) && (dif_w[MSB] != c_neg);
                res = sat ? (p_neg ? S_MAX : S_MIN) : dif_w;
            end
            MAC_U_ADD: begin
                sat = (sum_w < acc);
                res = sat ? U_MAX : sum_w;
            end
            MAC_U_SUB: begin
                sat = (dif_w > acc);
                res = sat ? U_MIN : dif_w;
            end
            default: begin
                sat = 1'b0;
                res = sum_w;
            end
        endcase
    end

    assign flags.sat = sat;
    assign flags.adv = res[MSB] ^ res[MSB-1];

endmodule

// File: rtl/mac_state.sv
module mac_state
    import mac_pkg::*;
#(
    parameter int ACW = 64
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clr_sticky,
    input  logic           valid_in,
    input  logic [ACW-1:0] res_next,
    input  mac_flags_t     flags_next,
    output logic [ACW-1:0] result,
    output mac_flags_t     flags_q,
    output mac_flags_t     sticky_q
);
    mac_flags_t sticky_base;

    // A clear drops the old record; the current operation still lands.
    assign sticky_base = clr_sticky ? '0 : sticky_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            result   <= '0;
            flags_q  <= '0;
            sticky_q <= '0;
        end else begin
            if (valid_in) begin
                result  <= res_next;
                flags_q <= flags_next;
            end
            sticky_q <= sticky_base | (valid_in ? flags_next : mac_flags_t'('0));
        end
    end

endmodule

// File: rtl/sat_mac64.sv
module sat_mac64
    import mac_pkg::*;
#(
    parameter int OPW = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_sticky,
    input  logic             valid_in,
    input  logic             signed_sel,
    input  logic             sub_sel,
    input  logic [OPW-1:0]   op_a,
    input  logic [OPW-1:0]   op_b,
    input  logic [2*OPW-1:0] acc_in,
    output logic [2*OPW-1:0] result,
    output logic             ovf,
    output logic             ovf_sticky,
    output logic             aov,
    output logic             aov_sticky
);
    localparam int ACW = 2 * OPW;
    localparam int MSB = ACW - 1;

    mac_kind_e      kind;
    logic [ACW-1:0] prod;
    logic [ACW-1:0] res_next;
    mac_flags_t     flags_next;
    mac_flags_t     flags_q;
    mac_flags_t     sticky_q;

    assign kind = mac_kind_f(signed_sel, sub_sel);

    mac_mult #(.OPW(OPW)) u_mult (
        .kind (kind),
        .a    (op_a),
        .b    (op_b),
        .prod (prod)
    );

    mac_accum #(.ACW(ACW)) u_accum (
        .kind  (kind),
        .acc   (acc_in),
        .prod  (prod),
        .res   (res_next),
        .flags (flags_next)
    );

    mac_state #(.ACW(ACW)) u_state (
        .clk        (clk),
        .rst        (rst),
        .clr_sticky (clr_sticky),
        .valid_in   (valid_in),
        .res_next   (res_next),
        .flags_next (flags_next),
        .result     (result),
        .flags_q    (flags_q),
        .sticky_q   (sticky_q)
    );

    assign ovf        = flags_q.sat;
    assign aov        = flags_q.adv;
    assign ovf_sticky = sticky_q.sat;
    assign aov_sticky = sticky_q.adv;

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (result == '0) && !ovf && !ovf_sticky && !aov && !aov_sticky);

    assert_uns_add_sat_R5: assert property (@(posedge clk) disable iff (rst)
        (valid_in && !signed_sel && !sub_sel) |=> (!ovf || (result == {ACW{1'b1}})));

    assert_uns_sub_sat_R6: assert property (@(posedge clk) disable iff (rst)
        (valid_in && !signed_sel && sub_sel) |=> (!ovf || (result == '0)));

    assert_sticky_follows_R7: assert property (@(posedge clk) disable iff (rst)
        valid_in |=> (!ovf || ovf_sticky));

    assert_sticky_keeps_R7: assert property (@(posedge clk) disable iff (rst)
        (ovf_sticky && !clr_sticky) |=> ovf_sticky);

    assert_adv_bits_R8: assert property (@(posedge clk) disable iff (rst)
        valid_in |=> (aov == (result[MSB] ^ result[MSB-1])));

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> ($stable(result) && $stable(ovf) && $stable(aov)));

    assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (clr_sticky && !valid_in) |=> (!ovf_sticky && !aov_sticky));

endmodule

// File: tb/tb_sat_mac64.sv
module tb_sat_mac64;

    typedef logic signed [131:0] wide_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Small instance: OPW=3, ACW=6
    logic       s_clr = 0, s_val = 0, s_sgn = 0, s_sub = 0;
    logic [2:0] s_a = '0, s_b = '0;
    logic [5:0] s_acc = '0;
    logic [5:0] s_res;
    logic       s_ovf, s_ovfs, s_aov, s_aovs;

    // Default instance: OPW=32, ACW=64
    logic        w_clr = 0, w_val = 0, w_sgn = 0, w_sub = 0;
    logic [31:0] w_a = '0, w_b = '0;
    logic [63:0] w_acc = '0;
    logic [63:0] w_res;
    logic        w_ovf, w_ovfs, w_aov, w_aovs;

    sat_mac64 #(.OPW(3)) dut (
        .clk(clk), .rst(rst), .clr_sticky(s_clr), .valid_in(s_val),
        .signed_sel(s_sgn), .sub_sel(s_sub), .op_a(s_a), .op_b(s_b),
        .acc_in(s_acc), .result(s_res), .ovf(s_ovf), .ovf_sticky(s_ovfs),
        .aov(s_aov), .aov_sticky(s_aovs)
    );

    sat_mac64 dut_wide (
        .clk(clk), .rst(rst), .clr_sticky(w_clr), .valid_in(w_val),
        .signed_sel(w_sgn), .sub_sel(w_sub), .op_a(w_a), .op_b(w_b),
        .acc_in(w_acc), .result(w_res), .ovf(w_ovf), .ovf_sticky(w_ovfs),
        .aov(w_aov), .aov_sticky(w_aovs)
    );

    // Exact arithmetic, then clamp to the range of the accumulator
    function automatic void model(input int opw, input int acw, input logic sgn,
                                  input logic sub, input logic [63:0] a,
                                  input logic [63:0] b, input logic [127:0] acc,
                                  output logic [127:0] res, output logic sat);
        wide_t one, ai, bi, ci, p, ex, lo, hi, r, mask;
        one = 1;
        ai = wide_t'({68'd0, a});
        bi = wide_t'({68'd0, b});
        ci = wide_t'({4'd0, acc});
        if (sgn && a[opw-1]) ai = ai - (one <<< opw);
        if (sgn && b[opw-1]) bi = bi - (one <<< opw);
        if (sgn && acc[acw-1]) ci = ci - (one <<< acw);
        p  = ai * bi;
        ex = sub ? (ci - p) : (ci + p);
        if (sgn) begin
            hi = (one <<< (acw - 1)) - one;
            lo = -(one <<< (acw - 1));
        end else begin
            hi = (one <<< acw) - one;
            lo = 0;
        end
        sat = (ex > hi) || (ex < lo);
        r = (ex > hi) ? hi : ((ex < lo) ? lo : ex);
        mask = (one <<< acw) - one;
        r = r & mask;
        res = r[127:0];
    endfunction

    task automatic check(input string tag, input logic [63:0] act_r,
                         input logic [63:0] exp_r, input logic [3:0] act_f,
                         input logic [3:0] exp_f);
        checks++;
        if (act_r !== exp_r || act_f !== exp_f) begin
            errors++;
            $display("FAIL %s: result=%h flags(ovf,ovfs,aov,aovs)=%b expected result=%h flags=%b",
                     tag, act_r, act_f, exp_r, exp_f);
        end
    endtask

    // Sticky state expected for each instance
    logic s_eo = 0, s_ea = 0, w_eo = 0, w_ea = 0;
    logic [5:0]  s_er = '0;
    logic        s_efo = 0, s_efa = 0;
    logic [63:0] w_er = '0;
    logic        w_efo = 0, w_efa = 0;

    task automatic small_op(input string tag, input logic clr, input logic val,
                            input logic sgn, input logic sub, input logic [2:0] a,
                            input logic [2:0] b, input logic [5:0] acc);
        logic [127:0] r;
        logic sat;
        @(negedge clk);
        s_clr = clr; s_val = val; s_sgn = sgn; s_sub = sub;
        s_a = a; s_b = b; s_acc = acc;
        model(3, 6, sgn, sub, {61'd0, a}, {61'd0, b}, {122'd0, acc}, r, sat);
        if (clr) begin s_eo = 0; s_ea = 0; end
        if (val) begin
            s_er  = r[5:0];
            s_efo = sat;
            s_efa = r[5] ^ r[4];
            s_eo  = s_eo | s_efo;
            s_ea  = s_ea | s_efa;
        end
        @(negedge clk);
        s_clr = 0; s_val = 0;
        check(tag, {58'd0, s_res}, {58'd0, s_er}, {s_ovf, s_ovfs, s_aov, s_aovs},
              {s_efo, s_eo, s_efa, s_ea});
    endtask

    task automatic wide_op(input string tag, input logic clr, input logic val,
                           input logic sgn, input logic sub, input logic [31:0] a,
                           input logic [31:0] b, input logic [63:0] acc);
        logic [127:0] r;
        logic sat;
        @(negedge clk);
        w_clr = clr; w_val = val; w_sgn = sgn; w_sub = sub;
        w_a = a; w_b = b; w_acc = acc;
        model(32, 64, sgn, sub, {32'd0, a}, {32'd0, b}, {64'd0, acc}, r, sat);
        if (clr) begin w_eo = 0; w_ea = 0; end
        if (val) begin
            w_er  = r[63:0];
            w_efo = sat;
            w_efa = r[63] ^ r[62];
            w_eo  = w_eo | w_efo;
            w_ea  = w_ea | w_efa;
        end
        @(negedge clk);
        w_clr = 0; w_val = 0;
        check(tag, w_res, w_er, {w_ovf, w_ovfs, w_aov, w_aovs},
              {w_efo, w_eo, w_efa, w_ea});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        string tag;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state of both instances
        check("R1 small", {58'd0, s_res}, 64'd0, {s_ovf, s_ovfs, s_aov, s_aovs}, 4'b0);
        check("R1 wide", w_res, 64'd0, {w_ovf, w_ovfs, w_aov, w_aovs}, 4'b0);

        // Full sweep of the small instance
        for (int m = 0; m < 4; m++) begin
            case (m)
                0: tag = "R5 R11 R7 R8 unsigned add";
                1: tag = "R6 R11 R7 R8 unsigned sub";
                2: tag = "R2 R3 R7 R8 signed add";
                default: tag = "R2 R4 R7 R8 signed sub";
            endcase
            for (int a = 0; a < 8; a++)
                for (int b = 0; b < 8; b++)
                    for (int c = 0; c < 64; c++)
                        small_op(tag, 1'b0, 1'b1, m[1], m[0], 3'(a), 3'(b), 6'(c));
        end

        // R9: inputs change with valid low, outputs hold
        small_op("R9 hold", 1'b0, 1'b0, 1'b1, 1'b0, 3'd3, 3'd3, 6'd31);
        // R10: clear alone, result and ovf kept
        small_op("R10 clear alone", 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 6'd0);
        // R10: clear with an overflowing op in the same cycle (3*3+31 signed)
        small_op("R10 clear with op", 1'b1, 1'b1, 1'b1, 1'b0, 3'd3, 3'd3, 6'd31);
        // R7: non-saturating op clears ovf, sticky stays
        small_op("R7 ovf clears sticky stays", 1'b0, 1'b1, 1'b0, 1'b0, 3'd1, 3'd1, 6'd1);

        // Directed cases on the default widths
        wide_op("R2 signed -1*2+10", 1'b0, 1'b1, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'd2, 64'd10);
        wide_op("R11 unsigned all-ones product", 1'b0, 1'b1, 1'b0, 1'b0,
                32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'd0);
        wide_op("R3 signed add to max", 1'b0, 1'b1, 1'b1, 1'b0, 32'h7FFF_FFFF, 32'h7FFF_FFFF,
                64'h7FFF_FFFF_FFFF_FFFF);
        wide_op("R3 signed add to min", 1'b0, 1'b1, 1'b1, 1'b0, 32'h8000_0000, 32'd1,
                64'h8000_0000_0000_0000);
        wide_op("R4 signed sub neg product to max", 1'b0, 1'b1, 1'b1, 1'b1, 32'h8000_0000,
                32'd1, 64'h7FFF_FFFF_FFFF_FFF0);
        wide_op("R4 signed sub pos product to min", 1'b0, 1'b1, 1'b1, 1'b1, 32'd5, 32'd7,
                64'h8000_0000_0000_0003);
        wide_op("R5 unsigned add carry", 1'b1, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
                64'hFFFF_FFFF_0000_0000);
        wide_op("R6 unsigned sub borrow", 1'b0, 1'b1, 1'b0, 1'b1, 32'd3, 32'd3, 64'd5);
        wide_op("R8 advance flag no overflow", 1'b1, 1'b1, 1'b1, 1'b0, 32'd1, 32'd1,
                64'h3FFF_FFFF_FFFF_FFFF);
        wide_op("R9 wide hold", 1'b0, 1'b0, 1'b0, 1'b1, 32'd9, 32'd9, 64'd0);
        wide_op("R10 wide clear", 1'b1, 1'b0, 1'b0, 1'b0, 32'd0, 32'd0, 64'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule